// File: doc/BRIEF.md
# Move-to-Front Fully Associative TLB

This block is a small fully associative translation buffer. Its entries are kept in recency order: slot 0 holds the most recently used translation and the last slot the least recently used one. A lookup presents a virtual page number together with an address-space tag, a virtual-machine tag, a security bit, an access mode and a debug flag. In the same cycle the block answers with a hit flag, the physical frame and the attributes of the chosen entry. A page walker fills the buffer through a separate insert port.

Besides complete translations, the buffer can hold partial entries that stand for intermediate walk levels. A lookup prefers the entry from the deepest level. An entry installed for one access class becomes unified once the other class uses it. The order of entries changes with a shifting move-to-front scheme that leaves the two most recent slots in place. Seven counters record hits and misses per access mode, plus hits on partial entries.

Top module: `mtf_tlb`

## Requirements
- R1: An accepted insert writes the new entry into slot 0 and moves every other entry one slot towards the end. The entry in the last slot is dropped. The new order is visible from the next cycle.
- R2: A non-debug lookup that hits at a slot above 1 moves the hit entry to slot 0 at the next edge. The entries that sat between slot 0 and the old slot minus one each move one slot further down. Entries beyond the old slot stay where they are.
- R3: A non-debug hit at slot 0 or slot 1 leaves the order of entries unchanged.
- R4: A debug lookup (lk_debug=1) returns the same hit data as a normal lookup. It changes no order, no entry type and no counter.
- R5: An entry matches when all of the following hold. It is valid. Its VPN equals the lookup VPN after the low 3*size bits are ignored (size is 0..3). Its ASID equals the lookup ASID, or the entry is global. Its VMID and its security bit both equal those of the lookup.
- R6: Slots are scanned from 0 upward, and the scan ends at the first matching complete (non-partial) entry. Among the matches seen up to that point, the one with the highest level wins. Between matches of equal level, the lowest slot wins.
- R7: The entry type is a 2-bit code: 01 instruction, 10 data, 11 unified. An execute lookup that hits an entry without the instruction bit, or a read or write lookup that hits an entry without the data bit, makes that entry unified from the next cycle. hit_kind shows the type as stored before this change.
- R8: A partial insert is accepted only when bit <level> of PART_MASK is set (the default enables levels 1 and 2). A refused insert changes nothing. Complete inserts are always accepted.
- R9: For non-debug lookups, mode 2 (execute) counts into the instruction hit or miss counter and mode 1 (write) into the write counters. Modes 0 and 3 count into the read counters. A hit on a partial entry also increments the partial-hit counter. All counters update at the next edge.
- R10: When an insert is accepted in the same cycle as a non-debug hit, the insert decides the new order. The move-to-front and the type change of that hit are dropped, but the lookup is still counted.
- R11: Reset leaves every entry invalid and every counter at zero. The hit outputs are combinational and follow lk_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_vmid | input | VMID_W | Lookup virtual-machine tag |
| lk_secure | input | 1 | Lookup security bit |
| lk_mode | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| lk_debug | input | 1 | Side-effect-free lookup |
| hit | output | 1 | Lookup hit |
| hit_slot | output | IDX_W | Slot of chosen entry |
| hit_pfn | output | PFN_W | Physical frame of chosen entry |
| hit_level | output | LVL_W | Walk level of chosen entry |
| hit_partial | output | 1 | Chosen entry is partial |
| hit_kind | output | 2 | Stored type of chosen entry |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | New entry virtual page |
| ins_pfn | input | PFN_W | New entry physical frame |
| ins_size | input | 2 | New entry size code |
| ins_asid | input | ASID_W | New entry address-space tag |
| ins_global | input | 1 | New entry ignores ASID |
| ins_vmid | input | VMID_W | New entry virtual-machine tag |
| ins_secure | input | 1 | New entry security bit |
| ins_level | input | LVL_W | New entry walk level |
| ins_partial | input | 1 | New entry is partial |
| ins_kind | input | 2 | New entry type code |
| cnt_inst_hit | output | CNT_W | Execute hits |
| cnt_inst_miss | output | CNT_W | Execute misses |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_part_hit | output | CNT_W | Hits on partial entries |

## Verification
After every reordering step the bench compares the full slot order against an arithmetic model. An off-by-one MRU window would move slot-1 hits or leave slot-2 hits in place, and a wrong shift range would duplicate or lose entries. It also sets up overlapping partial and complete entries so that the deepest level must win, an earlier complete match must end the scan, and ties must go to the lower slot. A selector that takes the first match, or one that ignores the complete-entry stop, returns the wrong frame. Other cases cover the size mask boundary, global entries, partial inserts refused by the mask, a promotion that lands one cycle late, debug lookups that must stay silent, and an insert that collides with a reordering hit, where a design giving priority to the hit shows a different order.

// File: rtl/mtf_tlb.sv
module mtf_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 12,
  parameter int PFN_W = 12,
  parameter int ASID_W = 4,
  parameter int VMID_W = 4,
  parameter int LVL_N = 4,
  parameter int SZ_STEP = 3,
  parameter int MRU_WIN = 1,
  parameter int CNT_W = 16,
  parameter logic [LVL_N-1:0] PART_MASK = 4'b0110,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_secure,
  input  logic [1:0]        lk_mode,
  input  logic              lk_debug,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_slot,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic [LVL_W-1:0]  hit_level,
  output logic              hit_partial,
  output logic [1:0]        hit_kind,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [1:0]        ins_size,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic              ins_global,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic              ins_secure,
  input  logic [LVL_W-1:0]  ins_level,
  input  logic              ins_partial,
  input  logic [1:0]        ins_kind,
  output logic [CNT_W-1:0]  cnt_inst_hit,
  output logic [CNT_W-1:0]  cnt_inst_miss,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_part_hit
);
  localparam int EW = 1 + VPN_W + PFN_W + 2 + ASID_W + 1 + VMID_W + 1 + LVL_W + 1 + 2;
  localparam logic [1:0] KIND_I = 2'b01;
  localparam logic [1:0] KIND_D = 2'b10;
  localparam logic [1:0] KIND_U = 2'b11;

  logic [ENTRIES-1:0][EW-1:0]     ent;
  logic [ENTRIES-1:0]             s_val, s_glb, s_sec, s_part;
  logic [ENTRIES-1:0][VPN_W-1:0]  s_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0]  s_pfn;
  logic [ENTRIES-1:0][1:0]        s_size, s_kind;
  logic [ENTRIES-1:0][ASID_W-1:0] s_asid;
  logic [ENTRIES-1:0][VMID_W-1:0] s_vmid;
  logic [ENTRIES-1:0][LVL_W-1:0]  s_lvl;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign {s_val[g], s_vpn[g], s_pfn[g], s_size[g], s_asid[g], s_glb[g],
            s_vmid[g], s_sec[g], s_lvl[g], s_part[g], s_kind[g]} = ent[g];
  end

  logic [ENTRIES-1:0] m;
  logic               found;
  logic [IDX_W-1:0]   sel;
  logic [LVL_W-1:0]   sel_lvl;

  always_comb begin
    logic [VPN_W-1:0] vmask;
    logic blocked;
    for (int i = 0; i < ENTRIES; i++) begin
      vmask = ~((VPN_W'(1) << (int'(s_size[i]) * SZ_STEP)) - VPN_W'(1));
      m[i] = s_val[i] && (((s_vpn[i] ^ lk_vpn) & vmask) == '0) &&
             (s_glb[i] || s_asid[i] == lk_asid) &&
             s_vmid[i] == lk_vmid && s_sec[i] == lk_secure;
    end
    found = 1'b0;
    sel = '0;
    sel_lvl = '0;
    blocked = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (m[i] && !blocked && (!found || s_lvl[i] > sel_lvl)) begin
        found = 1'b1;
        sel = IDX_W'(i);
        sel_lvl = s_lvl[i];
      end
      if (m[i] && !s_part[i]) blocked = 1'b1;
    end
  end

  assign hit         = lk_valid && found;
  assign hit_slot    = sel;
  assign hit_pfn     = s_pfn[sel];
  assign hit_level   = s_lvl[sel];
  assign hit_partial = hit && s_part[sel];
  assign hit_kind    = s_kind[sel];

  wire [1:0] acc      = (lk_mode == 2'd2) ? KIND_I : KIND_D;
  wire [1:0] new_kind = ((s_kind[sel] & acc) != 2'b00) ? s_kind[sel] : KIND_U;
  wire       ins_ok   = ins_valid && (!ins_partial || PART_MASK[ins_level]);
  wire       upd      = hit && !lk_debug;
  wire       move     = upd && (sel > IDX_W'(MRU_WIN));
  wire [EW-1:0] new_ent = {1'b1, ins_vpn, ins_pfn, ins_size, ins_asid, ins_global,
                           ins_vmid, ins_secure, ins_level, ins_partial, ins_kind};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent <= '0;
    end else if (ins_ok) begin
      for (int i = ENTRIES - 1; i > 0; i--) ent[i] <= ent[i-1];
      ent[0] <= new_ent;
    end else if (move) begin
      for (int i = 1; i < ENTRIES; i++)
        if (i <= int'(sel)) ent[i] <= ent[i-1];
      ent[0] <= {ent[sel][EW-1:2], new_kind};
    end else if (upd) begin
      ent[sel][1:0] <= new_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_inst_hit <= '0; cnt_inst_miss <= '0;
      cnt_rd_hit <= '0;   cnt_rd_miss <= '0;
      cnt_wr_hit <= '0;   cnt_wr_miss <= '0;
      cnt_part_hit <= '0;
    end else if (lk_valid && !lk_debug) begin
      case (lk_mode)
        2'd2:    if (hit) cnt_inst_hit <= cnt_inst_hit + CNT_W'(1);
                 else     cnt_inst_miss <= cnt_inst_miss + CNT_W'(1);
        2'd1:    if (hit) cnt_wr_hit <= cnt_wr_hit + CNT_W'(1);
                 else     cnt_wr_miss <= cnt_wr_miss + CNT_W'(1);
        default: if (hit) cnt_rd_hit <= cnt_rd_hit + CNT_W'(1);
                 else     cnt_rd_miss <= cnt_rd_miss + CNT_W'(1);
      endcase
      if (hit_partial) cnt_part_hit <= cnt_part_hit + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mtf_tlb_chk.sv
module mtf_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int EW = 40,
  parameter int VPN_W = 12,
  parameter int LVL_N = 4,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3,
  parameter int LVL_W = 2,
  parameter logic [LVL_N-1:0] PART_MASK = 4'b0110
) (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_debug,
  input logic [1:0] lk_mode,
  input logic hit,
  input logic hit_partial,
  input logic [IDX_W-1:0] hit_slot,
  input logic ins_valid,
  input logic ins_partial,
  input logic [LVL_W-1:0] ins_level,
  input logic [VPN_W-1:0] ins_vpn,
  input logic [ENTRIES-1:0][EW-1:0] ent,
  input logic [CNT_W-1:0] cnt_inst_hit,
  input logic [CNT_W-1:0] cnt_rd_miss,
  input logic [CNT_W-1:0] cnt_part_hit
);
  // R11
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> lk_valid);
  // R9
  inst_hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_debug && lk_mode == 2'd2 && hit) |=> cnt_inst_hit == $past(cnt_inst_hit) + CNT_W'(1));
  // R9
  part_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_partial |-> hit);
  // R4
  debug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_debug && !ins_valid) |=> ($stable(ent) && $stable(cnt_rd_miss) && $stable(cnt_part_hit)));
  // R1
  insert_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_partial) |=> (ent[0][EW-1] && ent[0][EW-2 -: VPN_W] == $past(ins_vpn)
                                     && ent[ENTRIES-1] == $past(ent[ENTRIES-2])));
  // R8
  refused_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_partial && !PART_MASK[ins_level] && !lk_valid) |=> $stable(ent));
  // R3
  mru_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lk_debug && !ins_valid && hit_slot <= IDX_W'(1)) |=> ent[1][EW-1:2] == $past(ent[1][EW-1:2]));
endmodule

bind mtf_tlb mtf_tlb_chk #(.ENTRIES(ENTRIES), .EW(EW), .VPN_W(VPN_W), .LVL_N(LVL_N),
  .CNT_W(CNT_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .PART_MASK(PART_MASK)) u_chk (.*);

// File: tb/mtf_tlb_bench.sv
module mtf_tlb_bench;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, lk_valid, lk_secure, lk_debug, ins_valid, ins_global, ins_secure, ins_partial;
  logic [11:0] lk_vpn, ins_vpn, ins_pfn;
  logic [3:0] lk_asid, lk_vmid, ins_asid, ins_vmid;
  logic [1:0] lk_mode, ins_size, ins_level, ins_kind;
  logic hit, hit_partial;
  logic [2:0] hit_slot;
  logic [11:0] hit_pfn;
  logic [1:0] hit_level, hit_kind;
  logic [15:0] c_ih, c_im, c_rh, c_rm, c_wh, c_wm, c_ph;

  mtf_tlb u_mtf_tlb (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_vmid, .lk_secure, .lk_mode, .lk_debug,
    .hit, .hit_slot, .hit_pfn, .hit_level, .hit_partial, .hit_kind,
    .ins_valid, .ins_vpn, .ins_pfn, .ins_size, .ins_asid, .ins_global, .ins_vmid,
    .ins_secure, .ins_level, .ins_partial, .ins_kind,
    .cnt_inst_hit(c_ih), .cnt_inst_miss(c_im), .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm),
    .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_part_hit(c_ph));

  int checks = 0, errors = 0;
  logic g_hit, g_part;
  logic [2:0] g_slot;
  logic [11:0] g_pfn;
  logic [1:0] g_lvl, g_kind;
  logic [11:0] m_vpn [8];
  logic m_val [8];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; lk_valid = 0; ins_valid = 0; lk_debug = 0; lk_mode = 0;
    lk_vpn = 0; lk_asid = 0; lk_vmid = 0; lk_secure = 0;
    ins_vpn = 0; ins_pfn = 0; ins_size = 0; ins_asid = 0; ins_global = 0;
    ins_vmid = 0; ins_secure = 0; ins_level = 0; ins_partial = 0; ins_kind = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_vpn[i] = 0; end
  endtask

  task automatic set_lk(input [11:0] v, input [3:0] a, input [3:0] vm, input s,
                        input [1:0] md, input d);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_vmid = vm; lk_secure = s; lk_mode = md; lk_debug = d;
  endtask

  task automatic grab();
    #1;
    g_hit = hit; g_slot = hit_slot; g_pfn = hit_pfn; g_lvl = hit_level;
    g_part = hit_partial; g_kind = hit_kind;
  endtask

  task automatic lk(input [11:0] v, input [3:0] a, input [3:0] vm, input s,
                    input [1:0] md, input d);
    set_lk(v, a, vm, s, md, d);
    grab();
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic set_ins(input [11:0] v, input [11:0] p, input [1:0] sz, input [3:0] a,
                         input gl, input [3:0] vm, input s, input [1:0] lv, input pt, input [1:0] k);
    ins_valid = 1; ins_vpn = v; ins_pfn = p; ins_size = sz; ins_asid = a; ins_global = gl;
    ins_vmid = vm; ins_secure = s; ins_level = lv; ins_partial = pt; ins_kind = k;
  endtask

  task automatic ins(input [11:0] v, input [11:0] p, input [1:0] sz, input [3:0] a,
                     input gl, input [3:0] vm, input s, input [1:0] lv, input pt, input [1:0] k);
    set_ins(v, p, sz, a, gl, vm, s, lv, pt, k);
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic m_push(input [11:0] v);
    for (int i = 7; i > 0; i--) begin m_vpn[i] = m_vpn[i-1]; m_val[i] = m_val[i-1]; end
    m_vpn[0] = v; m_val[0] = 1;
  endtask

  task automatic m_move(input int idx);
    logic [11:0] t;
    t = m_vpn[idx];
    for (int i = idx; i > 0; i--) m_vpn[i] = m_vpn[i-1];
    m_vpn[0] = t;
  endtask

  task automatic ins_std(input [11:0] v);
    ins(v, v ^ 12'h5A5, 2'd0, 4'd1, 1'b0, 4'd2, 1'b0, 2'd3, 1'b0, 2'b10);
    m_push(v);
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s++) if (m_val[s]) begin
      lk(m_vpn[s], 4'd1, 4'd2, 1'b0, 2'd0, 1'b1);
      chk(g_hit && g_slot == 3'(s) && g_pfn == (m_vpn[s] ^ 12'h5A5), tag,
          {g_hit, g_slot, g_pfn}, {1'b1, 3'(s), m_vpn[s] ^ 12'h5A5});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    lk(12'h010, 1, 2, 0, 0, 0);
    chk(!g_hit, "R11 empty after reset", g_hit, 0);
    chk({c_ih, c_im, c_rh, c_wh, c_wm, c_ph} == '0 && c_rm == 16'd1, "R11 counters from zero",
        c_rm, 1);
    do_reset();

    // R1 fill and evict
    for (int k = 0; k < 8; k++) ins_std(12'h010 + 12'(k));
    sweep("R1 fill order");
    chk({c_ih, c_im, c_rh, c_rm, c_wh, c_wm} == '0, "R4 debug lookups not counted", c_rh, 0);
    ins_std(12'h020);
    sweep("R1 after eviction");
    lk(12'h010, 1, 2, 0, 0, 1);
    chk(!g_hit, "R1 last slot dropped", g_hit, 0);

    // R3 MRU window
    lk(m_vpn[1], 1, 2, 0, 0, 0);
    chk(g_hit && g_slot == 1, "R3 hit at slot 1", g_slot, 1);
    sweep("R3 order kept slot1");
    lk(m_vpn[0], 1, 2, 0, 1, 0);
    sweep("R3 order kept slot0");
    // R2 move to front
    for (int idx = 2; idx < 8; idx++) begin
      lk(m_vpn[idx], 1, 2, 0, 0, 0);
      chk(g_hit && g_slot == 3'(idx), "R2 hit slot", g_slot, idx);
      m_move(idx);
      sweep("R2 order after move");
    end

    // R10 insert beats reorder
    set_lk(m_vpn[6], 1, 2, 0, 0, 0);
    set_ins(12'h030, 12'h030 ^ 12'h5A5, 0, 1, 0, 2, 0, 3, 0, 2'b10);
    grab();
    @(negedge clk);
    lk_valid = 0; ins_valid = 0;
    m_push(12'h030);
    sweep("R10 insert wins");

    // R5 matching
    do_reset();
    ins(12'h040, 12'h111, 2'd1, 1, 0, 2, 0, 3, 0, 2'b10);
    lk(12'h047, 1, 2, 0, 0, 1);
    chk(g_hit && g_pfn == 12'h111, "R5 size mask low bits", g_pfn, 12'h111);
    lk(12'h048, 1, 2, 0, 0, 1);
    chk(!g_hit, "R5 size mask boundary", g_hit, 0);
    lk(12'h040, 3, 2, 0, 0, 1);
    chk(!g_hit, "R5 asid mismatch", g_hit, 0);
    lk(12'h040, 1, 3, 0, 0, 1);
    chk(!g_hit, "R5 vmid mismatch", g_hit, 0);
    lk(12'h040, 1, 2, 1, 0, 1);
    chk(!g_hit, "R5 secure mismatch", g_hit, 0);
    ins(12'h100, 12'h222, 2'd0, 5, 1, 2, 0, 3, 0, 2'b10);
    lk(12'h100, 9, 2, 0, 0, 1);
    chk(g_hit && g_pfn == 12'h222, "R5 global any asid", g_pfn, 12'h222);

    // R6 level selection
    do_reset();
    ins(12'h080, 12'h001, 0, 1, 0, 2, 0, 2'd1, 1, 2'b10);
    ins(12'h080, 12'h002, 0, 1, 0, 2, 0, 2'd2, 1, 2'b10);
    ins(12'h080, 12'h0F1, 0, 1, 0, 2, 0, 2'd1, 1, 2'b10);
    lk(12'h080, 1, 2, 0, 0, 1);
    chk(g_hit && g_lvl == 2 && g_pfn == 12'h002 && g_part, "R6 deepest level wins", g_pfn, 12'h002);
    ins(12'h080, 12'h003, 0, 1, 0, 2, 0, 2'd2, 1, 2'b10);
    lk(12'h080, 1, 2, 0, 0, 1);
    chk(g_pfn == 12'h003 && g_slot == 0, "R6 tie lowest slot", g_pfn, 12'h003);
    ins(12'h080, 12'h004, 0, 1, 0, 2, 0, 2'd1, 0, 2'b10);
    lk(12'h080, 1, 2, 0, 0, 1);
    chk(g_pfn == 12'h004 && g_lvl == 1 && !g_part, "R6 complete match ends scan", g_pfn, 12'h004);
    ins(12'h090, 12'h005, 0, 1, 0, 2, 0, 2'd2, 1, 2'b10);
    lk(12'h090, 1, 2, 0, 0, 0);
    lk(12'h080, 1, 2, 0, 0, 0);
    #1;
    chk(c_ph == 16'd1 && c_rh == 16'd2, "R9 partial hit counter", c_ph, 1);
    @(negedge clk);

    // R8 partial level mask
    do_reset();
    ins_std(12'h0A0);
    ins(12'h0B0, 12'h0, 0, 1, 0, 2, 0, 2'd0, 1, 2'b10);
    lk(12'h0B0, 1, 2, 0, 0, 1);
    chk(!g_hit, "R8 level0 partial refused", g_hit, 0);
    ins(12'h0B1, 12'h0, 0, 1, 0, 2, 0, 2'd3, 1, 2'b10);
    lk(12'h0B1, 1, 2, 0, 0, 1);
    chk(!g_hit, "R8 level3 partial refused", g_hit, 0);
    sweep("R8 refused insert keeps order");
    ins(12'h0B2, 12'h0, 0, 1, 0, 2, 0, 2'd1, 1, 2'b10);
    m_push(12'h0B2);
    lk(12'h0B2, 1, 2, 0, 0, 1);
    chk(g_hit && g_slot == 0, "R8 level1 partial accepted", g_slot, 0);
    lk(12'h0A0, 1, 2, 0, 0, 1);
    chk(g_hit && g_slot == 1, "R8 order after accepted partial", g_slot, 1);

    // R7 promotion
    do_reset();
    ins(12'h0C0, 12'h0, 0, 1, 0, 2, 0, 3, 0, 2'b10);
    ins(12'h0C1, 12'h0, 0, 1, 0, 2, 0, 3, 0, 2'b01);
    lk(12'h0C1, 1, 2, 0, 2, 0);
    lk(12'h0C1, 1, 2, 0, 2, 0);
    chk(g_kind == 2'b01, "R7 exec keeps instruction type", g_kind, 1);
    lk(12'h0C1, 1, 2, 0, 1, 0);
    chk(g_kind == 2'b01, "R7 kind shown before promotion", g_kind, 1);
    lk(12'h0C1, 1, 2, 0, 0, 1);
    chk(g_kind == 2'b11, "R7 data access promotes", g_kind, 3);
    lk(12'h0C0, 1, 2, 0, 2, 1);
    lk(12'h0C0, 1, 2, 0, 0, 1);
    chk(g_kind == 2'b10, "R4 debug exec does not promote", g_kind, 2);
    lk(12'h0C0, 1, 2, 0, 2, 0);
    lk(12'h0C0, 1, 2, 0, 0, 1);
    chk(g_kind == 2'b11 && g_slot == 1, "R7 exec promotes data entry", g_kind, 3);

    // R9 counters
    do_reset();
    ins_std(12'h001);
    lk(12'h001, 1, 2, 0, 2, 0); lk(12'h001, 1, 2, 0, 2, 0); lk(12'h002, 1, 2, 0, 2, 0);
    lk(12'h001, 1, 2, 0, 1, 0); lk(12'h002, 1, 2, 0, 1, 0); lk(12'h003, 1, 2, 0, 1, 0);
    for (int k = 0; k < 3; k++) lk(12'h001, 1, 2, 0, 0, 0);
    lk(12'h004, 1, 2, 0, 3, 0);
    lk(12'h001, 1, 2, 0, 2, 1); lk(12'h009, 1, 2, 0, 1, 1);
    chk(c_ih == 2, "R9 inst hits", c_ih, 2);
    chk(c_im == 1, "R9 inst misses", c_im, 1);
    chk(c_wh == 1 && c_wm == 2, "R9 write counters", {c_wh, c_wm}, {16'd1, 16'd2});
    chk(c_rh == 3 && c_rm == 1, "R9 read counters with mode 3", {c_rh, c_rm}, {16'd3, 16'd1});
    chk(c_ph == 0, "R9 no partial hits", c_ph, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule